// File: doc/BRIEF.md
# Temperature Conversion Sequencer with Qualified Shutdown

This block schedules temperature conversions for a sensor front end. In run mode it starts one conversion after another. Each conversion occupies a number of clock cycles that depends on the selected resolution. When a conversion ends, the block copies the converter's output into the temperature result register and raises a data-available flag.

The block enters a low-activity halt mode only after the halt request has stayed high for one full conversion time at the current resolution. A shorter pulse has no effect. In halt mode no conversion runs on its own. A single-conversion request starts exactly one conversion. Until that conversion finishes, the result register holds the sentinel code 8000h, which stands for -256 °C.

The analog converter is represented by a cycle-counting stub. When the countdown ends, the stub returns the word present on `sample_in`.

Top module: `tconv_sequencer`

## Requirements
- R1: While in run mode, the block enters halt mode (`halted`=1) after `halt_req` has been sampled high on CYC(`res_sel`) consecutive clock edges. A low sample restarts the count. Entering halt mode aborts any running conversion, so `busy`=0.
- R2: In halt mode, a low `halt_req` returns the block to run mode at the next edge. A new conversion then starts at the following edge if none is running.
- R3: In halt mode with no conversion running, `single_req` sampled high together with `halt_req` starts exactly one conversion and one result update. No further conversion starts without a new request.
- R4: `single_req` has no effect in run mode. The conversion schedule and the result match a run without the request.
- R5: `single_req` has no effect while a conversion is running.
- R6: `temp_out` reads 16'h8000 after reset and from the edge that enters halt mode. It keeps that value until a conversion completes.
- R7: `data_avail` is 0 during reset. It clears at the edge that starts a conversion and stays 0 while `busy`=1. It becomes 1 at the completing edge and clears on halt entry.
- R8: A conversion keeps `busy` high for exactly CYC(r) cycles. Here r is `res_sel` sampled at the start edge, and codes 0, 1, 2, 3 select CYC0, CYC1, CYC2, CYC3.
- R9: At the completing edge, `temp_out` loads `sample_in` bit for bit, with bit 0 as the least significant data bit.
- R10: After reset the block is in run mode and starts a conversion at the first edge. In run mode the next conversion starts one cycle after each completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | 1 | Halt request control bit |
| single_req | input | 1 | Single-conversion request |
| res_sel | input | 2 | Resolution code selecting conversion time |
| sample_in | input | DATA_W | Data the converter stub returns at completion |
| conv_start | output | 1 | High in a cycle whose edge starts a conversion |
| busy | output | 1 | Conversion in progress |
| data_avail | output | 1 | Result register holds completed data |
| halted | output | 1 | Block is in halt mode |
| temp_out | output | DATA_W | Temperature result register |

## Verification
The bench builds the block with conversion times of 3, 5, 8 and 13 cycles. These values are short enough that full halt qualifications, single conversions and resolution changes during a conversion all fit in a short run. Because the four values differ, a wrong resolution decode shows up as a busy window of the wrong length. The three-cycle setting lets a halt request held one cycle too short be checked against one held exactly long enough, and lets a conversion aborted partway by halt entry be checked against one allowed to finish.

// File: rtl/tconv_pkg.sv
package tconv_pkg;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_HALT = 1'b1
  } mode_e;

  // Conversion length for a resolution code.
  function automatic int unsigned cycles_for(input logic [1:0] code,
                                             input int unsigned c0,
                                             input int unsigned c1,
                                             input int unsigned c2,
                                             input int unsigned c3);
    int unsigned r;
    case (code)
      2'd0:    r = c0;
      2'd1:    r = c1;
      2'd2:    r = c2;
      default: r = c3;
    endcase
    return r;
  endfunction

  // True when one more high sample completes the qualification window.
  function automatic logic hold_complete(input int unsigned held,
                                         input int unsigned need);
    return (held + 1) >= need;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/tconv_mode_ctl.sv
module tconv_mode_ctl #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic [CNT_W-1:0] need,
  output logic             halted,
  output logic             enter_halt,
  output logic             leave_halt
);
  import tconv_pkg::*;

  mode_e            mode_q;
  logic [CNT_W-1:0] hold_q;

  assign halted     = (mode_q == MODE_HALT);
  assign enter_halt = (mode_q == MODE_RUN) && halt_req &&
                      hold_complete(int'(hold_q), int'(need));
  assign leave_halt = (mode_q == MODE_HALT) && !halt_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      hold_q <= '0;
    end else begin
      if (enter_halt) begin
        mode_q <= MODE_HALT;
        hold_q <= '0;
      end else begin
        if (leave_halt) mode_q <= MODE_RUN;
        if ((mode_q == MODE_RUN) && halt_req) hold_q <= hold_q + 1'b1;
        else                                  hold_q <= '0;
      end
    end
  end

  AST_HALT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(halt_req)); // R1
  AST_LEAVE_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !halt_req) |=> !halted); // R2

endmodule

// File: rtl/tconv_conv_stub.sv
module tconv_conv_stub #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [CNT_W-1:0]  cycles,
  input  logic [DATA_W-1:0] sample_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  logic             busy_q;
  logic [CNT_W-1:0] left_q;

  assign busy   = busy_q;
  assign done   = busy_q && (left_q == '0) && !abort;
  assign result = sample_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      left_q <= cycles - 1'b1;
    end else if (busy_q) begin
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R5
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q); // R8
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy_q); // R1

endmodule

// File: rtl/tconv_result_reg.sv
module tconv_result_reg #(
  parameter int                 DATA_W   = 16,
  parameter logic [DATA_W-1:0]  SENTINEL = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              start,
  input  logic              done,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] temp,
  output logic              avail
);
  logic [DATA_W-1:0] temp_q;
  logic              avail_q;

  assign temp  = temp_q;
  assign avail = avail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q  <= SENTINEL;
      avail_q <= 1'b0;
    end else if (clear) begin
      temp_q  <= SENTINEL;
      avail_q <= 1'b0;
    end else if (done) begin
      temp_q  <= data;
      avail_q <= 1'b1;
    end else if (start) begin
      avail_q <= 1'b0;
    end
  end

  AST_LOAD_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> (temp_q == $past(data)) && avail_q); // R9
  AST_CLEAR_SENTINEL: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (temp_q == SENTINEL) && !avail_q); // R6

endmodule

// File: rtl/tconv_sequencer.sv
module tconv_sequencer #(
  parameter int          DATA_W = 16,
  parameter int unsigned CYC0   = 4,
  parameter int unsigned CYC1   = 6,
  parameter int unsigned CYC2   = 10,
  parameter int unsigned CYC3   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req,
  input  logic              single_req,
  input  logic [1:0]        res_sel,
  input  logic [DATA_W-1:0] sample_in,
  output logic              conv_start,
  output logic              busy,
  output logic              data_avail,
  output logic              halted,
  output logic [DATA_W-1:0] temp_out
);
  import tconv_pkg::*;

  localparam int unsigned       MAX_CYC  = max4(CYC0, CYC1, CYC2, CYC3);
  localparam int                CNT_W    = $clog2(MAX_CYC + 1);
  localparam logic [DATA_W-1:0] SENTINEL = {1'b1, {(DATA_W-1){1'b0}}};

  logic [CNT_W-1:0]  need;
  logic              enter_halt;
  logic              leave_halt;
  logic              conv_busy;
  logic              conv_done;
  logic [DATA_W-1:0] conv_data;
  logic              run_go;
  logic              single_go;

  assign need = CNT_W'(cycles_for(res_sel, CYC0, CYC1, CYC2, CYC3));

  tconv_mode_ctl #(.CNT_W(CNT_W)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_req   (halt_req),
    .need       (need),
    .halted     (halted),
    .enter_halt (enter_halt),
    .leave_halt (leave_halt)
  );

  // Named start events for the assertions.
  assign run_go     = !conv_busy && !halted && !enter_halt;
  assign single_go  = !conv_busy && halted && halt_req && single_req;
  assign conv_start = run_go || single_go;

  tconv_conv_stub #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (conv_start),
    .abort     (enter_halt),
    .cycles    (need),
    .sample_in (sample_in),
    .busy      (conv_busy),
    .done      (conv_done),
    .result    (conv_data)
  );

  tconv_result_reg #(.DATA_W(DATA_W), .SENTINEL(SENTINEL)) u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (enter_halt),
    .start (conv_start),
    .done  (conv_done),
    .data  (conv_data),
    .temp  (temp_out),
    .avail (data_avail)
  );

  assign busy = conv_busy;

  AST_DAV_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !data_avail); // R7
  AST_HALT_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && halted) |-> single_req); // R3
  AST_SENTINEL_ON_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (temp_out == SENTINEL)); // R6
  AST_NO_START_ON_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    leave_halt |-> !conv_start); // R2

endmodule

// File: tb/tconv_sequencer_test.sv
module tconv_sequencer_test;
  localparam int C0 = 3, C1 = 5, C2 = 8, C3 = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt_req = 1'b0;
  logic        single_req = 1'b0;
  logic [1:0]  res_sel = 2'd0;
  logic [15:0] sample_in = 16'h1234;
  logic        conv_start, busy, data_avail, halted;
  logic [15:0] temp_out;

  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  string phase = "R10";

  tconv_sequencer #(.DATA_W(16), .CYC0(C0), .CYC1(C1), .CYC2(C2), .CYC3(C3)) uut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .single_req(single_req),
    .res_sel(res_sel), .sample_in(sample_in), .conv_start(conv_start),
    .busy(busy), .data_avail(data_avail), .halted(halted), .temp_out(temp_out));

  always #5 clk = ~clk;

  function automatic int len_of(input logic [1:0] r);
    int t [4] = '{C0, C1, C2, C3};
    return t[r];
  endfunction

  // Behavioural reference: remaining-cycle count and plain flags.
  bit          m_halt, m_busy, m_dav;
  int          m_held, m_left;
  logic [15:0] m_temp;
  bit          go_down, may_start;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_halt = 0; m_busy = 0; m_dav = 0; m_held = 0; m_left = 0; m_temp = 16'h8000;
    end else begin
      go_down   = !m_halt && halt_req && (m_held + 1 >= len_of(res_sel));
      may_start = m_halt ? (halt_req && single_req) : 1'b1;
      if (go_down) begin
        m_halt = 1; m_held = 0; m_busy = 0; m_left = 0; m_temp = 16'h8000; m_dav = 0;
      end else begin
        m_held = (!m_halt && halt_req) ? m_held + 1 : 0;
        if (m_halt && !halt_req) m_halt = 0;
        if (m_busy) begin
          if (m_left == 1) begin m_busy = 0; m_temp = sample_in; m_dav = 1; end
          else m_left = m_left - 1;
        end else if (may_start) begin
          m_busy = 1; m_left = len_of(res_sel); m_dav = 0;
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", req, phase, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference.
  bit cmp_on = 0;
  int rises = 0;
  bit prev_busy = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R8 busy",       busy,       m_busy);
      check("R7 data_avail", data_avail, m_dav);
      check("R1 halted",     halted,     m_halt);
      check("R9 temp_out",   temp_out,   m_temp);
    end
    if (busy && !prev_busy) rises++;
    prev_busy = busy;
  end

  always @(negedge clk) sample_in <= sample_in * 16'd5 + 16'h0137;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cyc(2);
    check("R6 reset temp", temp_out, 16'h8000);
    check("R7 reset dav", data_avail, 1'b0);
    check("R8 reset busy", busy, 1'b0);
    rst_n = 1'b1;
    cmp_on = 1;
    cyc(1);
    check("R10 first start", busy, 1'b1);
    check("R10 run mode", halted, 1'b0);
    cyc(30);
    phase = "R8";
    res_sel = 2'd2; cyc(25);
    res_sel = 2'd1; cyc(3); res_sel = 2'd3; cyc(30);
    res_sel = 2'd0;
    phase = "R4";
    single_req = 1'b1; cyc(12); single_req = 1'b0; cyc(1);
    single_req = 1'b1; cyc(1); single_req = 1'b0; cyc(8);

    phase = "R1";
    halt_req = 1'b1; cyc(C0 - 1); halt_req = 1'b0; cyc(1);
    check("R1 short hold", halted, 1'b0);
    cyc(2);
    halt_req = 1'b1; cyc(C0);
    check("R1 entered", halted, 1'b1);
    check("R1 aborted", busy, 1'b0);
    check("R6 sentinel", temp_out, 16'h8000);
    check("R7 dav cleared", data_avail, 1'b0);
    cyc(10);
    check("R6 sentinel held", temp_out, 16'h8000);

    phase = "R3";
    res_sel = 2'd1;
    rises = 0;
    single_req = 1'b1; cyc(1); single_req = 1'b0;
    check("R3 started", busy, 1'b1);
    cyc(3 * C1);
    check("R3 one conversion", rises, 1);
    check("R3 idle after", busy, 1'b0);
    check("R7 dav set", data_avail, 1'b1);
    check("R9 loaded", temp_out, m_temp);

    phase = "R5";
    rises = 0;
    single_req = 1'b1; cyc(4); single_req = 1'b0;
    cyc(3 * C1);
    check("R5 repeat ignored", rises, 1);

    phase = "R2";
    halt_req = 1'b0; cyc(1);
    check("R2 left halt", halted, 1'b0);
    cyc(1);
    check("R2 restart", busy, 1'b1);
    cyc(20);

    phase = "R1";
    res_sel = 2'd2; cyc(3);
    halt_req = 1'b1; cyc(len_of(2'd2));
    check("R1 entered again", halted, 1'b1);
    res_sel = 2'd3;
    single_req = 1'b1; cyc(1); single_req = 1'b0;
    cyc(C3 + 3);
    phase = "R2";
    halt_req = 1'b0; cyc(30);
    cmp_on = 0;
    finish_run();
  end

endmodule